// File: doc/BRIEF.md
# Capture Pixel Format Packer

This block sits in a video capture path, after colour conversion and before the write port of the frame memory. Each cycle it can take one pixel, given as three 8-bit components. For RGB capture these are red, green and blue. For YCbCr capture they are luma and the two chroma samples. The block turns each pixel into the memory word of the selected storage format and hands the word on through a valid/ready handshake.

Three configuration bits choose the format:

- `cfg_ycc` selects 16-bit luma/chroma pairs and overrides the other two bits.
- Otherwise `cfg_deep` selects 32-bit words (full 8-bit components) or 16-bit words (5-bit components).
- `cfg_rgba` then selects whether the colour components lead or the alpha part leads.

In the RGB formats a one-bit blend flag is taken from `blend_bit` at the moment each pixel is accepted, and placed according to the ordering. The configuration bits are only sampled on the `frame_start` strobe, so one frame never mixes formats.

The output side is a single-word register run by a two-state machine:

- **EMPTY**: no word is held. A pixel that arrives takes transition LOAD into HOLD.
- **HOLD**: a word is offered. While the word is not taken, transition STALL keeps the word. When the word is taken and a new pixel arrives in the same cycle, transition STREAM reloads the register. When the word is taken and no pixel arrives, transition DRAIN returns to EMPTY.

Top module: `capture_pixel_packer`

## Requirements
- R1: Reset state. After reset `out_valid` is 0 and `in_ready` is 1. The active format is 16-bit alpha-first, and it stays in force until the first `frame_start`.
- R2: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R3: Handshake timing.
  - `in_ready` equals `!out_valid || out_ready`.
  - A pixel accepted at a clock edge (`in_valid && in_ready`) is presented on `out_data`, with `out_valid` 1, from that edge on.
- R4: 16-bit alpha-first format (`cfg_ycc`=0, `cfg_deep`=0, `cfg_rgba`=0). Bit 15 is the blend flag. Bits 14:10 are red[7:3], bits 9:5 are green[7:3] and bits 4:0 are blue[7:3].
- R5: 16-bit alpha-last format (`cfg_ycc`=0, `cfg_deep`=0, `cfg_rgba`=1). Bits 15:11 are red[7:3], bits 10:6 are green[7:3], bits 5:1 are blue[7:3], and bit 0 is the blend flag.
- R6: 32-bit alpha-first format (`cfg_ycc`=0, `cfg_deep`=1, `cfg_rgba`=0). Bit 31 is the blend flag and bits 30:24 are zero. Bits 23:16 are red, 15:8 are green and 7:0 are blue.
- R7: 32-bit alpha-last format (`cfg_ycc`=0, `cfg_deep`=1, `cfg_rgba`=1). Bits 31:24 are red, 23:16 are green and 15:8 are blue. Bits 7:1 are zero and bit 0 is the blend flag.
- R8: Luma/chroma format (`cfg_ycc`=1, whatever the other two bits are).
  - Bits 15:8 are the luma (`in_c0`).
  - Bits 7:0 alternate between Cb (`in_c1`) on even accepted pixels and Cr (`in_c2`) on odd accepted pixels.
  - The count restarts at even on every `frame_start`.
- R9: In the luma/chroma format, `blend_bit` has no effect on `out_data`.
- R10: Configuration changes take effect only at a `frame_start` strobe. A pixel accepted in the same cycle as the strobe still uses the previous format.
- R11: In the 16-bit formats, bits 31:16 of `out_data` are zero.
- R12: Every accepted pixel leaves exactly once, in acceptance order. `out_valid` falls after a word is taken unless a new pixel was accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame boundary strobe; loads configuration and restarts chroma alternation |
| cfg_ycc | input | 1 | Select luma/chroma 16-bit packing |
| cfg_deep | input | 1 | Select 32-bit words (1) or 16-bit words (0) for RGB |
| cfg_rgba | input | 1 | Select alpha-last (1) or alpha-first (0) ordering |
| blend_bit | input | 1 | Blend flag, sampled with each accepted pixel |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Pixel can be accepted |
| in_c0 | input | 8 | Red or luma |
| in_c1 | input | 8 | Green or Cb |
| in_c2 | input | 8 | Blue or Cr |
| out_valid | output | 1 | Packed word offered |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Packed memory word |

## Verification
The bench goes after the points where a format could be misapplied.

- **Strobe coincident with a pixel.** A design that applied the new configuration one cycle early would pack that pixel in the new layout.
- **Configuration change with no strobe.** A design that did not latch the configuration would switch format in mid-frame.
- **Odd pixel count before a new frame.** A design that did not restart the chroma count at the strobe would emit Cr where Cb belongs.
- **Blend bit in the 16-bit layouts.** A swapped flag position or a wrong slice of the components shows up as a word mismatch.
- **Long stalls and stream-through cycles.** A faulty hold state would drop, repeat or overwrite a word, and the in-order reference queue would then disagree.

// File: rtl/cpk_pkg.sv
package cpk_pkg;

    typedef enum logic [2:0] {
        FMT_ARGB16 = 3'd0,
        FMT_RGBA16 = 3'd1,
        FMT_ARGB32 = 3'd2,
        FMT_RGBA32 = 3'd3,
        FMT_YCC16  = 3'd4
    } fmt_e;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } ost_e;

    function automatic fmt_e decode_fmt(input logic ycc, input logic deep, input logic rgba);
        fmt_e f;
        if (ycc)
            f = FMT_YCC16;
        else if (deep)
            f = rgba ? FMT_RGBA32 : FMT_ARGB32;
        else
            f = rgba ? FMT_RGBA16 : FMT_ARGB16;
        return f;
    endfunction

endpackage

// File: rtl/cpk_cfg_latch.sv
module cpk_cfg_latch
    import cpk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic cfg_ycc,
    input  logic cfg_deep,
    input  logic cfg_rgba,
    input  logic accept,
    output fmt_e act_fmt,
    output logic ycc_odd
);

    fmt_e fmt_q;
    logic odd_q;

    // Format register: loaded only at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q <= FMT_ARGB16;
        end else if (frame_start) begin
            fmt_q <= decode_fmt(cfg_ycc, cfg_deep, cfg_rgba);
        end
    end

    // Chroma alternation: toggles per accepted pixel, restarts at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_q <= 1'b0;
        end else if (frame_start) begin
            odd_q <= 1'b0;
        end else if (accept) begin
            odd_q <= ~odd_q;
        end
    end

    assign act_fmt = fmt_q;
    assign ycc_odd = odd_q;

endmodule

// File: rtl/cpk_pack_fmt.sv
module cpk_pack_fmt
    import cpk_pkg::*;
#(
    parameter int COMP_W  = 8,
    parameter int SHORT_W = 5,
    parameter int WORD_W  = 32
) (
    input  fmt_e              fmt,
    input  logic              ycc_odd,
    input  logic              blend,
    input  logic [COMP_W-1:0] c0,
    input  logic [COMP_W-1:0] c1,
    input  logic [COMP_W-1:0] c2,
    output logic [WORD_W-1:0] word
);

    localparam int S16_W = 3 * SHORT_W + 1;
    localparam int D32_W = 4 * COMP_W;
    localparam int YC_W  = 2 * COMP_W;
    localparam int PAD_W = COMP_W - 1;

    logic [SHORT_W-1:0] s0, s1, s2;

    // Reduced components keep the most significant bits.
    assign s0 = c0[COMP_W-1 -: SHORT_W];
    assign s1 = c1[COMP_W-1 -: SHORT_W];
    assign s2 = c2[COMP_W-1 -: SHORT_W];

    always_comb begin
        word = '0;
        unique case (fmt)
            FMT_ARGB16: word[S16_W-1:0] = {blend, s0, s1, s2};
            FMT_RGBA16: word[S16_W-1:0] = {s0, s1, s2, blend};
            FMT_ARGB32: word[D32_W-1:0] = {blend, {PAD_W{1'b0}}, c0, c1, c2};
            FMT_RGBA32: word[D32_W-1:0] = {c0, c1, c2, {PAD_W{1'b0}}, blend};
            FMT_YCC16:  word[YC_W-1:0]  = {c0, (ycc_odd ? c2 : c1)};
            default:    word = '0;
        endcase
    end

endmodule

// File: rtl/cpk_out_stage.sv
module cpk_out_stage
    import cpk_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] din,
    output logic              in_ready,
    output logic              accept,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);

    ost_e              st_q, st_d;
    logic [WORD_W-1:0] data_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state: LOAD, STREAM, STALL, DRAIN.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: if (accept) st_d = ST_HOLD;                 // LOAD
            ST_HOLD:  if (out_ready && !accept) st_d = ST_EMPTY;  // DRAIN
            default:  st_d = ST_EMPTY;
        endcase
    end

    // Outputs.
    always_comb begin
        out_valid = 1'b0;
        in_ready  = 1'b0;
        unique case (st_q)
            ST_EMPTY: begin
                out_valid = 1'b0;
                in_ready  = 1'b1;
            end
            ST_HOLD: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
            end
            default: begin
                out_valid = 1'b0;
                in_ready  = 1'b0;
            end
        endcase
        accept = in_valid && in_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (accept) begin
            data_q <= din;
        end
    end

    assign out_data = data_q;

endmodule

// File: rtl/capture_pixel_packer.sv
module capture_pixel_packer
    import cpk_pkg::*;
#(
    parameter int COMP_W  = 8,
    parameter int SHORT_W = 5,
    parameter int WORD_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              cfg_ycc,
    input  logic              cfg_deep,
    input  logic              cfg_rgba,
    input  logic              blend_bit,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [COMP_W-1:0] in_c0,
    input  logic [COMP_W-1:0] in_c1,
    input  logic [COMP_W-1:0] in_c2,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);

    fmt_e              act_fmt;
    logic              ycc_odd;
    logic              accept;
    logic [WORD_W-1:0] packed_w;

    cpk_cfg_latch u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .cfg_ycc     (cfg_ycc),
        .cfg_deep    (cfg_deep),
        .cfg_rgba    (cfg_rgba),
        .accept      (accept),
        .act_fmt     (act_fmt),
        .ycc_odd     (ycc_odd)
    );

    cpk_pack_fmt #(
        .COMP_W  (COMP_W),
        .SHORT_W (SHORT_W),
        .WORD_W  (WORD_W)
    ) u_pack (
        .fmt     (act_fmt),
        .ycc_odd (ycc_odd),
        .blend   (blend_bit),
        .c0      (in_c0),
        .c1      (in_c1),
        .c2      (in_c2),
        .word    (packed_w)
    );

    cpk_out_stage #(
        .WORD_W (WORD_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .din       (packed_w),
        .in_ready  (in_ready),
        .accept    (accept),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

endmodule

// File: rtl/capture_pixel_packer_chk.sv
module capture_pixel_packer_chk
    import cpk_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input fmt_e              act_fmt
);

    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r3_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (!out_valid || out_ready));

    a_r3_load_shows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r10_fmt_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(act_fmt));

    a_r12_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);

endmodule

bind capture_pixel_packer capture_pixel_packer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .act_fmt     (act_fmt)
);

// File: tb/capture_pixel_packer_bench.sv
`timescale 1ns/1ps
module capture_pixel_packer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_start, cfg_ycc, cfg_deep, cfg_rgba, blend_bit;
    logic        in_valid, in_ready, out_valid, out_ready;
    logic [7:0]  in_c0, in_c1, in_c2;
    logic [31:0] out_data;

    int n_checks = 0;
    int n_errs   = 0;
    int k        = 0;   // index of the next pixel to offer

    // Reference model state.
    logic [31:0] exp_q[$];
    string       tag_q[$];
    int          m_fmt = 0;      // 0 a16, 1 r16, 2 a32, 3 r32, 4 ycc
    bit          m_odd = 1'b0;
    string       tag_force = "";

    always #10 clk = ~clk;   // 50 MHz

    capture_pixel_packer u_capture_pixel_packer (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_ycc(cfg_ycc), .cfg_deep(cfg_deep), .cfg_rgba(cfg_rgba),
        .blend_bit(blend_bit), .in_valid(in_valid), .in_ready(in_ready),
        .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_word(input int f, input bit odd, input bit bl,
                                               input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        logic [31:0] w;
        w = 32'h0;
        case (f)
            0: w = {16'h0, bl, a[7:3], b[7:3], c[7:3]};
            1: w = {16'h0, a[7:3], b[7:3], c[7:3], bl};
            2: w = {bl, 7'h0, a, b, c};
            3: w = {a, b, c, 7'h0, bl};
            default: w = {16'h0, a, (odd ? c : b)};
        endcase
        return w;
    endfunction

    function automatic string fmt_tag(input int f);
        case (f)
            0: return "R4 R11";
            1: return "R5 R11";
            2: return "R6";
            3: return "R7";
            default: return "R8 R9 R11";
        endcase
    endfunction

    function automatic int cfg_code();
        if (cfg_ycc) return 4;
        if (cfg_deep) return cfg_rgba ? 3 : 2;
        return cfg_rgba ? 1 : 0;
    endfunction

    // One clock: drive at the falling edge, evaluate the model just after,
    // then wait for the next falling edge.
    task automatic cycle(input bit fs, input bit pv, input bit rdy);
        frame_start = fs;
        in_valid    = pv;
        out_ready   = rdy;
        in_c0       = 8'(k * 29 + 7);
        in_c1       = 8'(k * 53 + 100);
        in_c2       = 8'(k * 91 + 3);
        blend_bit   = ((k % 3) == 0);
        #1;
        // R3: ready rule
        check(in_ready === (!out_valid || out_ready), "R3", {31'h0, in_ready}, {31'h0, (!out_valid || out_ready)});
        // R12: output present exactly when a word is pending
        check(out_valid === (exp_q.size() > 0), "R12", {31'h0, out_valid}, {31'h0, (exp_q.size() > 0)});
        if (out_valid && out_ready && exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_data === e, t, out_data, e);
        end
        if (in_valid && in_ready) begin
            exp_q.push_back(model_word(m_fmt, m_odd, blend_bit, in_c0, in_c1, in_c2));
            tag_q.push_back(tag_force != "" ? tag_force : fmt_tag(m_fmt));
            m_odd = ~m_odd;
            k++;
        end
        if (fs) begin
            m_fmt = cfg_code();
            m_odd = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 1'b1);
    endtask

    task automatic run_frame(input bit y, input bit d, input bit r, input int n);
        cfg_ycc = y; cfg_deep = d; cfg_rgba = r;
        cycle(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < n; i++) cycle(1'b0, (i % 3) != 2, (i % 4) != 1);
        drain();
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        frame_start = 0; cfg_ycc = 1; cfg_deep = 0; cfg_rgba = 0;
        blend_bit = 0; in_valid = 0; out_ready = 0;
        in_c0 = 0; in_c1 = 0; in_c2 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state of the handshake
        check(out_valid === 1'b0, "R1", {31'h0, out_valid}, 32'h0);
        check(in_ready === 1'b1, "R1", {31'h0, in_ready}, 32'h1);
        @(negedge clk);

        // R1 R10: no strobe yet, so 16-bit alpha-first applies despite cfg_ycc=1
        tag_force = "R1 R10";
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, 1'b1);
        drain();
        tag_force = "";

        run_frame(1'b0, 1'b0, 1'b0, 12);   // R4
        run_frame(1'b0, 1'b0, 1'b1, 12);   // R5
        run_frame(1'b0, 1'b1, 1'b0, 12);   // R6
        run_frame(1'b0, 1'b1, 1'b1, 12);   // R7
        run_frame(1'b1, 1'b0, 1'b0, 12);   // R8 R9
        run_frame(1'b1, 1'b1, 1'b1, 9);    // R8: cfg_ycc overrides the others

        // R10: change cfg mid-frame without a strobe
        cfg_ycc = 0; cfg_deep = 1; cfg_rgba = 1;
        cycle(1'b1, 1'b0, 1'b1);
        cfg_ycc = 1; cfg_deep = 0;
        tag_force = "R10";
        for (int i = 0; i < 5; i++) cycle(1'b0, 1'b1, 1'b1);
        // R10: strobe coincident with a pixel keeps the old format for it
        cfg_ycc = 0; cfg_deep = 0; cfg_rgba = 1;
        cycle(1'b1, 1'b1, 1'b1);
        cycle(1'b0, 1'b1, 1'b1);
        drain();
        tag_force = "";

        // R8: odd count then new frame restarts at Cb
        cfg_ycc = 1;
        cycle(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, 1'b1);
        tag_force = "R8";
        cycle(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 1'b1);
        drain();
        tag_force = "";

        // R2 R12: long stall then stream-through
        cfg_ycc = 0; cfg_deep = 1; cfg_rgba = 0;
        cycle(1'b1, 1'b0, 1'b1);
        tag_force = "R2 R12";
        for (int i = 0; i < 6; i++) cycle(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) cycle(1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 6; i++) cycle(1'b0, (i % 2) == 0, (i % 3) == 0);
        drain();
        tag_force = "";

        check(exp_q.size() == 0, "R12", 32'(exp_q.size()), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule